// File: doc/BRIEF.md
# Set-Associative Translation Buffer with Command Register Interface

This block is a main translation buffer organised as sets of ways, placed in front of a small fully associative micro buffer. Software drives it through four 32-bit registers: an entry key register (virtual page number, address-space tag, present bit), an entry payload register (frame number and attribute bits), an index register, and a command register. Writing a code to the command register performs one operation in that same cycle: look up a key, pick a slot for a new key, store the staged entry with or without clearing the micro buffer, load an entry back into the registers, or clear the micro buffer.

The translation side takes a page number and address-space tag. It checks the micro buffer first. On a micro miss it searches the main set on the next cycle and, on a hit, copies the entry into the micro buffer. Because one store command does not clear the micro buffer, recently used translations can survive eviction from a 2-way set. This hides the thrashing that three pages sharing one set would otherwise cause.

Top module: `jtlb_cmd_engine`

## Requirements
- R1: After reset, the key, payload and index registers read 0, every main and micro entry is invalid, and `lk_ready` is 1.
- R2: Register addresses are 0 = key, 1 = payload, 2 = index, 3 = command (write only, reads 0). Key layout: page number in bits 31:13, present in bit 8, tag in bits 7:0, bits 12:9 ignored. The frame number is payload bits 31:13. Command codes: 1 load, 2 store-and-clear, 3 store-keep, 4 probe, 5 pick-slot, 6 clear-micro.
- R3: A store writes the staged key and payload to linear entry `set*WAYS+way` taken from the index register. A load returns that entry's key (bits 12:9 zero) and payload into the registers.
- R4: A probe whose key (page number plus tag, with the set from the low page bits) matches exactly one valid way writes that linear index into the index register.
- R5: A probe with no match writes 0x8000_0000 to the index register. A probe with two or more matching ways writes 0xC000_0000.
- R6: An entry stored with present = 0 never matches a probe or a translation.
- R7: Pick-slot writes the index of the lowest-numbered invalid way of the key's set.
- R8: When the set is full, pick-slot uses a per-set round-robin pointer. The pointer starts at way 0 and advances only when it is used.
- R9: Store-and-clear empties the micro buffer. Store-keep leaves it untouched, so a stale micro entry keeps translating.
- R10: Clear-micro empties the micro buffer and leaves the main array unchanged.
- R11: A translation that hits the micro buffer raises `lk_done` one cycle after the request. A micro miss raises it two cycles after and fills the micro buffer on a main hit.
- R12: A main miss gives `lk_hit` = 0 with frame 0 and fills nothing. `lk_ready` is 0 during the main-search cycle.
- R13: The micro buffer (8 entries) replaces round-robin. The ninth distinct fill evicts the oldest one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the addressed register |
| lk_req | input | 1 | Translation request (taken when lk_ready) |
| lk_vpn | input | 19 | Virtual page number to translate |
| lk_asid | input | 8 | Address-space tag to translate |
| lk_ready | output | 1 | Able to accept a translation request |
| lk_done | output | 1 | One-cycle result strobe |
| lk_hit | output | 1 | Translation found (valid with lk_done) |
| lk_pfn | output | 19 | Translated frame number (valid with lk_done) |

## Verification
The bench targets micro-buffer coherence. After store-keep, a stale frame must still come back in one cycle; after store-and-clear or clear-micro, the fresh frame must come back in two. A design that flushed on both stores, or on neither, would show the wrong latency or the wrong frame. It also forces a duplicate key into one set, fills a set to test round-robin slot choice, stores a non-present entry, and runs nine fills to prove eviction order. A design that preferred the pointer over a free way, decoded duplicates as hits, or matched non-present entries would return the wrong index code. Random stores, probes and translations in a few crowded sets are checked against a reference model.

// File: rtl/jtlb_pkg.sv
package jtlb_pkg;
    parameter int VPN_W  = 19;
    parameter int ASID_W = 8;
    parameter int PD_W   = 32;
    parameter int PFN_W  = 19;

    typedef struct packed {
        logic              valid;
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic [PD_W-1:0]   pd1;
    } tlb_entry_t;

    typedef enum logic [2:0] {
        OP_NONE       = 3'd0,
        OP_READ       = 3'd1,
        OP_WRITE      = 3'd2,
        OP_WRITE_KEEP = 3'd3,
        OP_PROBE      = 3'd4,
        OP_PICK       = 3'd5,
        OP_UFLUSH     = 3'd6
    } tlb_op_e;

    localparam logic [1:0] RA_KEY = 2'd0;
    localparam logic [1:0] RA_PAY = 2'd1;
    localparam logic [1:0] RA_IDX = 2'd2;
    localparam logic [1:0] RA_CMD = 2'd3;

    localparam logic [PD_W-1:0] IDX_MISS = 32'h8000_0000;
    localparam logic [PD_W-1:0] IDX_DUP  = 32'hC000_0000;

    function automatic logic [PD_W-1:0] pack_key(tlb_entry_t e);
        return {e.vpn, {(PD_W-VPN_W-ASID_W-1){1'b0}}, e.valid, e.asid};
    endfunction
endpackage

// File: rtl/jtlb_main_array.sv
module jtlb_main_array
    import jtlb_pkg::*;
#(
    parameter int SETS = 128,
    parameter int WAYS = 2,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS),
    localparam int IDX_W = SET_W + WAY_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [SET_W-1:0]        cmd_set,
    output tlb_entry_t [WAYS-1:0]   cmd_ways,
    output logic [WAY_W-1:0]        cmd_rr,
    input  logic                    rr_bump,
    input  logic [SET_W-1:0]        lk_set,
    output tlb_entry_t [WAYS-1:0]   lk_ways,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  tlb_entry_t              wr_entry
);
    tlb_entry_t       mem_q [SETS*WAYS];
    logic [WAY_W-1:0] rr_q  [SETS];

    for (genvar w = 0; w < WAYS; w++) begin : g_port
        assign cmd_ways[w] = mem_q[{cmd_set, WAY_W'(w)}];
        assign lk_ways[w]  = mem_q[{lk_set,  WAY_W'(w)}];
    end
    assign cmd_rr = rr_q[cmd_set];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SETS*WAYS; i++) mem_q[i] <= '0;
            for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
        end else begin
            if (wr_en) mem_q[wr_idx] <= wr_entry;
            if (rr_bump) rr_q[cmd_set] <= rr_q[cmd_set] + 1'b1;
        end
    end
endmodule

// File: rtl/jtlb_micro.sv
module jtlb_micro
    import jtlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int PTR_W = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VPN_W-1:0]  key_vpn,
    input  logic [ASID_W-1:0] key_asid,
    output logic              hit,
    output logic [PD_W-1:0]   hit_pd1,
    input  logic              flush,
    input  logic              fill_en,
    input  tlb_entry_t        fill_entry
);
    typedef struct packed {
        tlb_entry_t [ENTRIES-1:0] slot;
        logic [PTR_W-1:0]         ptr;
    } micro_t;

    micro_t q, d;
    logic [ENTRIES-1:0] match;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign match[i] = q.slot[i].valid && q.slot[i].vpn == key_vpn
                          && q.slot[i].asid == key_asid;
    end

    always_comb begin
        hit     = |match;
        hit_pd1 = '0;
        for (int i = 0; i < ENTRIES; i++)
            if (match[i]) hit_pd1 = hit_pd1 | q.slot[i].pd1;
        d = q;
        if (flush) begin
            for (int i = 0; i < ENTRIES; i++) d.slot[i].valid = 1'b0;
        end else if (fill_en) begin
            d.slot[q.ptr] = fill_entry;
            d.ptr         = q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assert_micro_unique_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));
    assert_micro_flushed_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !hit);
endmodule

// File: rtl/jtlb_cmd_engine.sv
module jtlb_cmd_engine
    import jtlb_pkg::*;
#(
    parameter int SETS   = 128,
    parameter int WAYS   = 2,
    parameter int UTLB_N = 8,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS),
    localparam int IDX_W = SET_W + WAY_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [PD_W-1:0]   reg_wdata,
    output logic [PD_W-1:0]   reg_rdata,
    input  logic              lk_req,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              lk_ready,
    output logic              lk_done,
    output logic              lk_hit,
    output logic [PFN_W-1:0]  lk_pfn
);
    typedef struct packed {
        logic [PD_W-1:0]   key;
        logic [PD_W-1:0]   pay;
        logic [PD_W-1:0]   index;
        logic              busy;
        logic [VPN_W-1:0]  lk_vpn;
        logic [ASID_W-1:0] lk_asid;
        logic              done;
        logic              hit;
        logic [PFN_W-1:0]  pfn;
    } eng_t;

    eng_t q, d;

    tlb_entry_t [WAYS-1:0] cmd_ways, lk_ways;
    logic [WAY_W-1:0] cmd_rr, probe_way, free_way, pick_way, lk_way;
    logic [WAYS-1:0]  pmatch, lmatch, freev;
    logic [SET_W-1:0] key_set, idx_set, cmd_set;
    logic [WAY_W-1:0] idx_way;
    logic             cmd_go, rr_bump, wr_en, flush, u_hit, main_hit;
    logic [PD_W-1:0]  u_pd1;
    tlb_entry_t       wr_entry, rd_entry;
    tlb_op_e          op;
    logic [VPN_W-1:0] key_vpn;
    logic [ASID_W-1:0] key_asid;
    logic             unused_bits;

    assign key_vpn  = q.key[PD_W-1 -: VPN_W];
    assign key_asid = q.key[ASID_W-1:0];
    assign key_set  = key_vpn[SET_W-1:0];
    assign idx_set  = q.index[IDX_W-1:WAY_W];
    assign idx_way  = q.index[WAY_W-1:0];
    assign cmd_go   = reg_we && reg_addr == RA_CMD;
    assign op       = tlb_op_e'(reg_wdata[2:0]);
    assign cmd_set  = (op == OP_PROBE || op == OP_PICK) ? key_set : idx_set;
    assign unused_bits = ^{q.key[PD_W-VPN_W-1:ASID_W+1], reg_wdata[PD_W-1:3],
                           q.index[PD_W-1:IDX_W]};

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign pmatch[w] = cmd_ways[w].valid && cmd_ways[w].vpn == key_vpn
                           && cmd_ways[w].asid == key_asid;
        assign lmatch[w] = lk_ways[w].valid && lk_ways[w].vpn == q.lk_vpn
                           && lk_ways[w].asid == q.lk_asid;
        assign freev[w]  = !cmd_ways[w].valid;
    end

    always_comb begin
        probe_way = '0;
        free_way  = '0;
        lk_way    = '0;
        for (int w = WAYS-1; w >= 0; w--) begin
            if (pmatch[w]) probe_way = WAY_W'(w);
            if (freev[w])  free_way  = WAY_W'(w);
            if (lmatch[w]) lk_way    = WAY_W'(w);
        end
    end

    assign pick_way = (|freev) ? free_way : cmd_rr;
    assign rr_bump  = cmd_go && op == OP_PICK && !(|freev);
    assign wr_en    = cmd_go && (op == OP_WRITE || op == OP_WRITE_KEEP);
    assign flush    = cmd_go && (op == OP_WRITE || op == OP_UFLUSH);
    assign wr_entry = '{valid: q.key[ASID_W], vpn: key_vpn, asid: key_asid, pd1: q.pay};
    assign rd_entry = cmd_ways[idx_way];
    assign main_hit = |lmatch;

    jtlb_main_array #(.SETS(SETS), .WAYS(WAYS)) u_main (
        .clk(clk), .rst_n(rst_n),
        .cmd_set(cmd_set), .cmd_ways(cmd_ways), .cmd_rr(cmd_rr), .rr_bump(rr_bump),
        .lk_set(q.lk_vpn[SET_W-1:0]), .lk_ways(lk_ways),
        .wr_en(wr_en), .wr_idx(q.index[IDX_W-1:0]), .wr_entry(wr_entry)
    );

    jtlb_micro #(.ENTRIES(UTLB_N)) u_micro (
        .clk(clk), .rst_n(rst_n),
        .key_vpn(lk_vpn), .key_asid(lk_asid), .hit(u_hit), .hit_pd1(u_pd1),
        .flush(flush), .fill_en(q.busy && main_hit), .fill_entry(lk_ways[lk_way])
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (reg_we) begin
            unique case (reg_addr)
                RA_KEY: d.key   = reg_wdata;
                RA_PAY: d.pay   = reg_wdata;
                RA_IDX: d.index = PD_W'(reg_wdata[IDX_W-1:0]);
                default: begin
                    case (op)
                        OP_READ: begin
                            d.key = pack_key(rd_entry);
                            d.pay = rd_entry.pd1;
                        end
                        OP_PROBE: begin
                            if ($countones(pmatch) == 0)      d.index = IDX_MISS;
                            else if ($countones(pmatch) == 1) d.index = PD_W'({key_set, probe_way});
                            else                              d.index = IDX_DUP;
                        end
                        OP_PICK: d.index = PD_W'({key_set, pick_way});
                        default: ;
                    endcase
                end
            endcase
        end
        if (q.busy) begin
            d.busy = 1'b0;
            d.done = 1'b1;
            d.hit  = main_hit;
            d.pfn  = main_hit ? lk_ways[lk_way].pd1[PD_W-1 -: PFN_W] : '0;
        end else if (lk_req) begin
            if (u_hit) begin
                d.done = 1'b1;
                d.hit  = 1'b1;
                d.pfn  = u_pd1[PD_W-1 -: PFN_W];
            end else begin
                d.busy    = 1'b1;
                d.lk_vpn  = lk_vpn;
                d.lk_asid = lk_asid;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (reg_addr)
            RA_KEY:  reg_rdata = q.key;
            RA_PAY:  reg_rdata = q.pay;
            RA_IDX:  reg_rdata = q.index;
            default: reg_rdata = '0;
        endcase
    end

    assign lk_ready = !q.busy;
    assign lk_done  = q.done;
    assign lk_hit   = q.hit;
    assign lk_pfn   = q.pfn;

    assert_search_one_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy |=> !q.busy);
    assert_done_needs_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> ($past(q.busy) || $past(lk_req)));
    assert_dup_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
        q.index[PD_W-2] |-> q.index[PD_W-1]);
    assert_miss_zero_frame_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (q.done && !q.hit) |-> q.pfn == '0);
endmodule

// File: tb/tb_jtlb_cmd_engine.sv
module tb_jtlb_cmd_engine;
    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_we = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic lk_req = 1'b0;
    logic [18:0] lk_vpn = '0;
    logic [7:0] lk_asid = '0;
    logic lk_ready, lk_done, lk_hit;
    logic [18:0] lk_pfn;

    int checks = 0, fails = 0;

    always #2 clk = ~clk;

    jtlb_cmd_engine dut (.*);

    // reference model for random region (entries 0..7)
    logic        m_valid [8];
    logic [18:0] m_vpn   [8];
    logic [7:0]  m_asid  [8];
    logic [31:0] m_pd1   [8];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_key(logic [18:0] vpn, logic [7:0] asid, logic p);
        return {vpn, 4'b0000, p, asid};
    endfunction

    task automatic reg_wr(input logic [1:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [31:0] v);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic put_entry(input int idx, input logic [31:0] key, input logic [31:0] pay, input logic [31:0] op);
        reg_wr(2, idx);
        reg_wr(0, key);
        reg_wr(1, pay);
        reg_wr(3, op);
    endtask

    task automatic probe(input logic [31:0] key, output logic [31:0] idx);
        reg_wr(0, key);
        reg_wr(3, 4);
        reg_rd(2, idx);
    endtask

    task automatic lookup(input logic [18:0] vpn, input logic [7:0] asid,
                          output logic hit, output logic [18:0] pfn, output int lat, output logic rdy_mid);
        @(negedge clk);
        lk_req = 1'b1; lk_vpn = vpn; lk_asid = asid;
        @(negedge clk);
        lk_req = 1'b0;
        lat = 1;
        rdy_mid = lk_ready;
        while (!lk_done && lat < 6) begin
            @(negedge clk);
            lat++;
        end
        hit = lk_hit;
        pfn = lk_pfn;
    endtask

    function automatic logic [31:0] exp_probe(logic [18:0] vpn, logic [7:0] asid);
        int n = 0;
        int found = 0;
        for (int w = 0; w < 2; w++) begin
            int i = vpn[6:0] * 2 + w;
            if (m_valid[i] && m_vpn[i] == vpn && m_asid[i] == asid) begin
                if (n == 0) found = i;
                n++;
            end
        end
        if (n == 0) return 32'h8000_0000;
        if (n == 1) return found;
        return 32'hC000_0000;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v, kA, kB, kC, kD;
        logic [31:0] P1, P2, P3;
        logic h, rdy;
        logic [18:0] pf;
        int lat;
        void'($urandom(32'd4242));
        for (int i = 0; i < 8; i++) m_valid[i] = 1'b0;
        P1 = {19'h00AB1, 13'h005};
        P2 = {19'h00CD2, 13'h003};
        P3 = {19'h00EF3, 13'h007};
        kA = mk_key(19'h00005, 8'd3, 1'b1);
        kB = mk_key(19'h00085, 8'd3, 1'b1);
        kC = mk_key(19'h00105, 8'd3, 1'b1);
        kD = mk_key(19'h0000A, 8'd0, 1'b1);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        reg_rd(0, v); chk(v == 0, "R1 key reset", v, 0);
        reg_rd(1, v); chk(v == 0, "R1 payload reset", v, 0);
        reg_rd(2, v); chk(v == 0, "R1 index reset", v, 0);
        chk(lk_ready == 1'b1, "R1 ready reset", lk_ready, 1);
        probe(kA, v); chk(v == 32'h8000_0000, "R1 R5 empty probe misses", v, 32'h8000_0000);

        // R2 R3 store and load back (set 5 way 0 -> index 10)
        put_entry(10, kA | 32'h0000_1E00, P1, 2);
        reg_wr(0, 0); reg_wr(1, 0); reg_wr(2, 10); reg_wr(3, 1);
        reg_rd(0, v); chk(v == kA, "R2 R3 load key", v, kA);
        reg_rd(1, v); chk(v == P1, "R3 load payload", v, P1);
        reg_rd(3, v); chk(v == 0, "R2 command reads zero", v, 0);

        // R4 probe hit, R5 miss with other tag
        probe(kA, v); chk(v == 10, "R4 probe hit index", v, 10);
        probe(mk_key(19'h00005, 8'd4, 1'b1), v); chk(v == 32'h8000_0000, "R5 probe other tag", v, 32'h8000_0000);

        // R7 free way preferred
        reg_wr(0, kB); reg_wr(3, 5); reg_rd(2, v); chk(v == 11, "R7 pick free way", v, 11);
        put_entry(11, kB, P2, 2);
        // R8 round robin on full set
        reg_wr(0, kC); reg_wr(3, 5); reg_rd(2, v); chk(v == 10, "R8 rr first", v, 10);
        reg_wr(3, 5); reg_rd(2, v); chk(v == 11, "R8 rr second", v, 11);
        reg_wr(3, 5); reg_rd(2, v); chk(v == 10, "R8 rr wrap", v, 10);

        // R5 duplicate
        put_entry(11, kA, P2, 3);
        probe(kA, v); chk(v == 32'hC000_0000, "R5 duplicate code", v, 32'hC000_0000);
        put_entry(11, kB, P2, 2);

        // R6 non-present entry
        put_entry(20, mk_key(19'h0000A, 8'd0, 1'b0), P1, 2);
        probe(kD, v); chk(v == 32'h8000_0000, "R6 non-present probe", v, 32'h8000_0000);
        lookup(19'h0000A, 8'd0, h, pf, lat, rdy);
        chk(h == 1'b0, "R6 R12 non-present lookup", h, 0);
        chk(pf == 0, "R12 miss frame zero", pf, 0);
        chk(rdy == 1'b0, "R12 ready low while searching", rdy, 0);
        chk(lat == 2, "R12 miss latency", lat, 2);
        lookup(19'h0000A, 8'd0, h, pf, lat, rdy);
        chk(lat == 2, "R12 miss not filled", lat, 2);

        // R11 fill then fast hit
        lookup(19'h00005, 8'd3, h, pf, lat, rdy);
        chk(h && pf == P1[31:13], "R11 main hit frame", pf, P1[31:13]);
        chk(lat == 2, "R11 main latency", lat, 2);
        lookup(19'h00005, 8'd3, h, pf, lat, rdy);
        chk(lat == 1 && h, "R11 micro latency", lat, 1);

        // R9 store-keep keeps stale micro entry
        put_entry(10, kA, P3, 3);
        lookup(19'h00005, 8'd3, h, pf, lat, rdy);
        chk(lat == 1 && pf == P1[31:13], "R9 store-keep stale frame", pf, P1[31:13]);
        // R10 clear micro
        reg_wr(3, 6);
        lookup(19'h00005, 8'd3, h, pf, lat, rdy);
        chk(lat == 2 && pf == P3[31:13], "R10 clear then fresh frame", pf, P3[31:13]);
        probe(kA, v); chk(v == 10, "R10 main untouched", v, 10);
        lookup(19'h00005, 8'd3, h, pf, lat, rdy);
        chk(lat == 1, "R11 refilled", lat, 1);
        put_entry(11, kB, P2, 2);
        lookup(19'h00005, 8'd3, h, pf, lat, rdy);
        chk(lat == 2 && pf == P3[31:13], "R9 store-and-clear flushes", lat, 2);

        // R13 round-robin eviction
        for (int i = 0; i < 9; i++)
            put_entry(128 + 2*i, mk_key(19'h140 + i, 8'd1, 1'b1), {19'h100 + i, 13'h0}, 2);
        reg_wr(3, 6);
        for (int i = 0; i < 8; i++) lookup(19'h140 + i, 8'd1, h, pf, lat, rdy);
        for (int i = 1; i < 8; i++) begin
            lookup(19'h140 + i, 8'd1, h, pf, lat, rdy);
            chk(lat == 1 && pf == 19'h100 + i, "R13 eight resident", lat, 1);
        end
        lookup(19'h148, 8'd1, h, pf, lat, rdy);
        chk(lat == 2, "R13 ninth fill", lat, 2);
        lookup(19'h140, 8'd1, h, pf, lat, rdy);
        chk(lat == 2 && pf == 19'h100, "R13 oldest evicted", lat, 2);
        lookup(19'h142, 8'd1, h, pf, lat, rdy);
        chk(lat == 1, "R13 younger kept", lat, 1);

        // random phase on sets 0..3 (R3 R4 R5 R6 R12)
        for (int it = 0; it < 300; it++) begin
            int sel = $urandom % 3;
            logic [18:0] rv = 19'($urandom % 4) | 19'(($urandom % 3) << 7);
            logic [7:0] ra = 8'($urandom % 2);
            if (sel == 0) begin
                int idx = $urandom % 8;
                logic p = ($urandom % 4) != 0;
                logic [31:0] pay = $urandom;
                put_entry(idx, mk_key(rv, ra, p), pay, 2);
                m_valid[idx] = p; m_vpn[idx] = rv; m_asid[idx] = ra; m_pd1[idx] = pay;
            end else if (sel == 1) begin
                logic [31:0] e = exp_probe(rv, ra);
                probe(mk_key(rv, ra, 1'b1), v);
                chk(v == e, "R4 R5 random probe", v, e);
            end else begin
                logic [31:0] e = exp_probe(rv, ra);
                logic eh = !e[31];
                logic [18:0] ep = eh ? m_pd1[e[2:0]][31:13] : 19'h0;
                if (e == 32'hC000_0000) begin
                    eh = 1'b1;
                    ep = m_pd1[rv[6:0]*2][31:13];
                end
                lookup(rv, ra, h, pf, lat, rdy);
                chk(h == eh && pf == ep, "R6 R12 random lookup", {h, 12'h0, pf}, {eh, 12'h0, ep});
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule